// File: doc/BRIEF.md
# Frame Period Meter

The block measures the length of each audio frame in cycles of the fast counting clock. A rising edge on the word-select input marks the start of a frame. The input must already be synchronous to the counting clock. While measurement is enabled, a counter runs between successive frame starts. At each frame start the result moves into a status field, and the counter restarts from zero. Software compares successive readings to find a change in the sample rate. The block can also raise an interrupt when a reading differs from the one before it.

A small register interface controls the block. It has a single-cycle write strobe, a word address and combinational read data. Word 0 is the control register and word 1 is the status register. Measurement does not start on the write that enables it. The meter first waits for the next frame start, then measures the whole frame that follows. This means the first reading is never a partial frame.

A four-state machine sequences the measurement:
- IDLE: disabled, counter held at zero.
- ARMED: enabled, waiting for the first frame start.
- FIRST: the first full frame is being counted, and its reading is never reported as a change.
- RUN: steady measurement, where each reading is compared with the previous one.

The transitions are:
- IDLE→ARMED when enable is seen.
- ARMED→FIRST on a frame start.
- FIRST→RUN on the next frame start.
- Any state→IDLE when enable is cleared.

Top module: `frame_period_meter`

## Requirements
- R1: The control register at word address 0 holds the enable in bit 0 and the interrupt enable in bit 16. Both bits are read/write and reset to 0.
- R2: Every other control bit reads as 0, and writing it has no effect. Word addresses other than 0 and 1 read as all zeros.
- R3: A frame start is a rising edge of the word-select input. After enable is set, the first frame start only arms the measurement and latches nothing.
- R4: Each later frame start while enabled copies the count into VALUE (status bits 15:0) and restarts the count at 0. VALUE equals the number of clock cycles between the two rising edges minus one. VALUE holds its value between frame starts and while disabled.
- R5: While enable is 0 the counter is held at zero and nothing is latched. Re-enabling starts again from the armed state, so the next reading covers a full frame.
- R6: The interrupt output is high exactly when the change flag is set and the interrupt enable is 1.
- R7: The change flag is status bit 31 and it is sticky. Writing status with bit 31 set clears it. Writing status with bit 31 clear leaves it unchanged, and no write affects VALUE.
- R8: The change flag is set when a new VALUE differs from the previous VALUE. The first VALUE latched after enabling never sets it.
- R9: The count saturates at 0xFFFF instead of wrapping. A frame longer than 65536 cycles reads as 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ws | input | 1 | Word-select input, synchronous to clk |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Combinational register read data |
| period_value | output | 16 | Last latched frame period (VALUE) |
| irq | output | 1 | Frame-period change interrupt |

## Verification
The bench enables the meter partway through a frame. A design that started counting at once would report a short first period and set the change flag spuriously. It disables the meter, changes the frame length, then re-enables it. This catches designs that keep a stale count, or that flag the first reading against the old one. It stops word-select for more than 65536 cycles. A wrapping counter would then return a small value instead of 0xFFFF. Random frame lengths and interrupt-enable settings then exercise write-one-to-clear, the interrupt gate and reserved-bit masking.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRST = 2'd2,
        ST_RUN   = 2'd3
    } fpm_state_e;

    localparam int REG_W         = 32;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 16;
    localparam int STAT_FLAG_BIT = 31;
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_STAT     = 1;

endpackage

// File: rtl/fpm_edge.sv
module fpm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ws,
    output logic rise
);
    logic ws_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ws_q <= 1'b0;
        else        ws_q <= ws;
    end

    assign rise = ws & ~ws_q;

    // A frame start is a single-cycle pulse (R3)
    assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/fpm_core.sv
module fpm_core
    import fpm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rise,
    input  logic             clr_flag,
    output logic [CNT_W-1:0] value,
    output logic             flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    fpm_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             counting, latch, set_flag;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en) state_d = ST_ARMED;
            ST_ARMED: if (!en) state_d = ST_IDLE;
                      else if (rise) state_d = ST_FIRST;
            ST_FIRST: if (!en) state_d = ST_IDLE;
                      else if (rise) state_d = ST_RUN;
            ST_RUN:   if (!en) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign counting = en && (state_q == ST_FIRST || state_q == ST_RUN);
    assign latch    = counting && rise;
    assign set_flag = latch && (state_q == ST_RUN) && (cnt_q != value);

    // outputs: counter, latched value, change flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            value <= '0;
            flag  <= 1'b0;
        end else begin
            if (!counting || rise)      cnt_q <= '0;
            else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
            if (latch) value <= cnt_q;
            flag <= set_flag | (flag & ~clr_flag);
        end
    end

    assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt_q == '0);
    assert_value_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(value));
    assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && counting && !rise) |=> cnt_q == CNT_MAX);
    assert_first_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRST && rise) |=> flag == $past(flag && !clr_flag));
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !set_flag) |=> !flag);
endmodule

// File: rtl/fpm_regs.sv
module fpm_regs
    import fpm_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  value,
    input  logic              flag,
    output logic              en,
    output logic              ie,
    output logic              clr_flag,
    output logic [REG_W-1:0]  rdata
);
    logic sel_ctrl, sel_stat;

    assign sel_ctrl = (addr == ADDR_W'(ADDR_CTRL));
    assign sel_stat = (addr == ADDR_W'(ADDR_STAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= 1'b0;
            ie <= 1'b0;
        end else if (wr_en && sel_ctrl) begin
            en <= wdata[CTRL_EN_BIT];
            ie <= wdata[CTRL_IE_BIT];
        end
    end

    assign clr_flag = wr_en && sel_stat && wdata[STAT_FLAG_BIT];

    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[CTRL_EN_BIT] = en;
            rdata[CTRL_IE_BIT] = ie;
        end else if (sel_stat) begin
            rdata[CNT_W-1:0]     = value;
            rdata[STAT_FLAG_BIT] = flag;
        end
    end

    assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel_ctrl) |=> ($stable(en) && $stable(ie)));
endmodule

// File: rtl/frame_period_meter.sv
module frame_period_meter
    import fpm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ws,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [CNT_W-1:0]  period_value,
    output logic              irq
);
    logic rise, en, ie, clr_flag, flag;

    fpm_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .ws   (ws),
        .rise (rise)
    );

    fpm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .value   (period_value),
        .flag    (flag),
        .en      (en),
        .ie      (ie),
        .clr_flag(clr_flag),
        .rdata   (rdata)
    );

    fpm_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .rise    (rise),
        .clr_flag(clr_flag),
        .value   (period_value),
        .flag    (flag)
    );

    assign irq = flag & ie;
endmodule

// File: tb/frame_period_meter_test.sv
module frame_period_meter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ws = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic [15:0] period_value;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int ws_per = 0;
    int ws_ph = 0;
    int cycles = 0;
    bit done = 1'b0;

    frame_period_meter uut (
        .clk(clk), .rst_n(rst_n), .ws(ws), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .period_value(period_value), .irq(irq)
    );

    always #4 clk = ~clk;

    // word-select generator: period ws_per, 0 holds ws low
    always @(negedge clk) begin
        if (ws_per == 0) begin
            ws_ph = 0;
            ws = 1'b0;
        end else begin
            ws_ph = (ws_ph + 1 >= ws_per) ? 0 : ws_ph + 1;
            ws = (ws_ph < ws_per / 2);
        end
    end

    function automatic logic [31:0] exp_value(int p);
        return (p - 1 >= 65535) ? 32'h0000_FFFF : 32'(p - 1);
    endfunction

    function automatic logic [31:0] exp_ctrl(logic [31:0] w);
        return w & 32'h0001_0001;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'd0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        int prev_p;
        void'($urandom(32'd20240611));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset state
        reg_read(2'd0, r); chk("R1 ctrl reset", r, 32'h0);
        reg_read(2'd1, r); chk("R4 status reset", r, 32'h0);
        chk("R6 irq reset", 32'(irq), 32'h0);

        // R2: reserved bits and unmapped address
        reg_write(2'd0, 32'hFFFF_FFFE);
        reg_read(2'd0, r); chk("R2 reserved masked", r, exp_ctrl(32'hFFFF_FFFE));
        reg_read(2'd2, r); chk("R2 unmapped reads zero", r, 32'h0);
        reg_write(2'd0, 32'h0);
        reg_read(2'd0, r); chk("R1 ctrl cleared", r, 32'h0);

        // R3: enable mid-frame, first reading is a full frame, no flag
        ws_per = 40;
        wait_cyc(57);
        reg_write(2'd0, 32'h0000_0001);
        wait_cyc(5 * 40);
        reg_read(2'd1, r); chk("R3 R8 armed first reading", r, exp_value(40));

        // R8: period change sets flag; R6 gate
        ws_per = 57;
        wait_cyc(40 + 4 * 57);
        reg_read(2'd1, r); chk("R8 change flagged", r, 32'h8000_0000 | exp_value(57));
        chk("R6 irq gated off", 32'(irq), 32'h0);
        reg_write(2'd0, 32'h0001_0001);
        wait_cyc(1);
        chk("R6 irq on", 32'(irq), 32'h1);

        // R7: writing 0 to bit 31 keeps flag, writing 1 clears it
        reg_write(2'd1, 32'h7FFF_FFFF);
        reg_read(2'd1, r); chk("R7 write zero no effect", r, 32'h8000_0000 | exp_value(57));
        reg_write(2'd1, 32'h8000_0000);
        reg_read(2'd1, r); chk("R7 w1c clears", r, exp_value(57));
        chk("R6 irq after clear", 32'(irq), 32'h0);

        // R5: disable, change period, value held; re-enable no flag
        reg_write(2'd0, 32'h0001_0000);
        ws_per = 90;
        wait_cyc(4 * 90);
        reg_read(2'd1, r); chk("R5 R4 value held while off", r, exp_value(57));
        reg_write(2'd0, 32'h0001_0001);
        wait_cyc(5 * 90);
        reg_read(2'd1, r); chk("R5 R8 re-enable unflagged", r, exp_value(90));
        chk("R8 irq stays low", 32'(irq), 32'h0);
        chk("R4 period_value port", 32'(period_value), exp_value(90));

        // R9: stopped word-select saturates the count
        ws_per = 0;
        wait_cyc(70000);
        ws_per = 30;
        @(posedge ws);
        wait_cyc(3);
        reg_read(2'd1, r); chk("R9 saturated reading", r, 32'h8000_0000 | exp_value(70000));
        wait_cyc(3 * 30);
        reg_read(2'd1, r); chk("R9 recovers", r, 32'h8000_0000 | exp_value(30));
        reg_write(2'd1, 32'h8000_0000);

        // random periods and interrupt enable
        prev_p = 30;
        for (int i = 0; i < 8; i++) begin
            int p;
            logic ie_b;
            p = 4 + int'($urandom_range(396));
            if (i == 3) p = prev_p;
            ie_b = 1'($urandom_range(1));
            reg_write(2'd0, {15'd0, ie_b, 15'd0, 1'b1});
            ws_per = p;
            wait_cyc(prev_p + 4 * p);
            reg_read(2'd1, r);
            chk("R4 R8 random reading",
                r, ((p != prev_p) ? 32'h8000_0000 : 32'h0) | exp_value(p));
            chk("R6 random irq", 32'(irq), 32'((p != prev_p) && ie_b));
            reg_write(2'd1, 32'h8000_0000);
            wait_cyc(2 * p);
            reg_read(2'd1, r); chk("R7 random steady", r, exp_value(p));
            prev_p = p;
        end

        done = 1'b1;
        finish_run();
    end
endmodule